// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block is the address front end of a synchronous burst memory. On each rising clock edge it may capture an external address, started by either of two address strobes: one driven from the processor side and one from the controller side. Three chip enables qualify the strobe. When they are not all true, the strobe turns the cycle into a deselect instead of a load.

Once an address has been loaded, the block can produce the remaining beats of a four-location burst by itself. A 2-bit beat counter steps only on edges where the advance input is high. Only the two lowest address bits ever change during a burst. A mode input picks the order of those bits:
- linear: the start value plus the beat count, wrapping within four;
- interleaved: the start value XOR the beat count.

Tying the mode input low gives interleaved order, which is the default.

Bursts are optional, because a fresh address can be loaded on every edge. The address sent to the memory array always comes from a register.

The controller has four states:
- `ST_DESEL`: deselected; this is the reset state.
- `ST_LOAD`: an address has just been captured.
- `ST_ADVANCE`: the last edge stepped the burst.
- `ST_SUSPEND`: the burst is paused with its address held.

The transitions are evaluated in this order:
- **qualified strobe**: any state goes to `ST_LOAD`.
- **unqualified strobe**: any state goes to `ST_DESEL`.
- **advance**: `ST_LOAD`, `ST_ADVANCE` or `ST_SUSPEND` goes to `ST_ADVANCE`.
- **idle**: `ST_LOAD`, `ST_ADVANCE` or `ST_SUSPEND` goes to `ST_SUSPEND`, while `ST_DESEL` stays in `ST_DESEL`.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `sel` is 0, `arr_addr` is 0 and `cpu_cycle` is 0.
- R2: A strobe on an edge where `ce_hi0`=1, `ce_hi1`=1 and `ce_lo_n`=0 makes `arr_addr` equal `addr_in` and `sel`=1 after that edge.
- R3: Either strobe alone starts a cycle. After a qualified start, `cpu_cycle` is 1 if `strobe_cpu` was high and 0 if only `strobe_ctl` was high, so the processor strobe wins when both are high.
- R4: A strobe on an edge where any chip enable is false gives `sel`=0 and `cpu_cycle`=0 after that edge, and `arr_addr` keeps its value.
- R5: An advance edge without a strobe, while `sel`=1, changes only `arr_addr[1:0]`. All upper bits are kept.
- R6: With `order_lin`=1, beat n of a burst (n = 0..3) has low bits equal to (start + n) mod 4.
- R7: With `order_lin`=0, beat n of a burst has low bits equal to start XOR n.
- R8: An edge with no strobe and `advance`=0 keeps `arr_addr` unchanged (suspend). A later advance resumes from the next beat.
- R9: `advance` while `sel`=0 has no effect on `arr_addr` or `sel`.
- R10: The beat counter wraps, so the fourth advance after a load returns the low bits to the start value.
- R11: Qualified strobes on consecutive edges load a new address on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_in | input | ADDR_W | External address |
| strobe_cpu | input | 1 | Processor-side address strobe, priority |
| strobe_ctl | input | 1 | Controller-side address strobe |
| advance | input | 1 | Step the burst counter |
| ce_hi0 | input | 1 | Chip enable, active high |
| ce_hi1 | input | 1 | Chip enable, active high |
| ce_lo_n | input | 1 | Chip enable, active low |
| order_lin | input | 1 | 1 selects linear order, 0 selects interleaved |
| arr_addr | output | ADDR_W | Registered address to the memory array |
| sel | output | 1 | Device selected (not deselected) |
| cpu_cycle | output | 1 | Current cycle was started by the processor strobe |

## Verification
The assertions take for granted that every input is steady and known around each rising edge, and that reset is applied before any strobe. The bench changes all inputs only on falling edges, and it holds reset through several edges before its first strobe. It never leaves a strobe, enable or mode input undriven, so the properties never see unknown values.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        ST_DESEL   = 2'd0,
        ST_LOAD    = 2'd1,
        ST_ADVANCE = 2'd2,
        ST_SUSPEND = 2'd3
    } seq_state_t;

    localparam int BEAT_W = 2;

    // Low address bits for a given beat count under either order.
    function automatic logic [BEAT_W-1:0] beat_low(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] count,
        input logic              linear
    );
        return linear ? (start + count) : (start ^ count);
    endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_cpu,
    input  logic       strobe_ctl,
    input  logic       advance,
    input  logic       ce_ok,
    output seq_state_t state,
    output logic       cpu_src,
    output logic       load_en,
    output logic       step_en
);

    seq_state_t state_nxt;
    logic       any_strobe;

    assign any_strobe = strobe_cpu | strobe_ctl;

    // Next-state decision.
    always_comb begin
        state_nxt = state;
        if (any_strobe) begin
            state_nxt = ce_ok ? ST_LOAD : ST_DESEL;
        end else begin
            unique case (state)
                ST_DESEL:   state_nxt = ST_DESEL;
                ST_LOAD,
                ST_ADVANCE,
                ST_SUSPEND: state_nxt = advance ? ST_ADVANCE : ST_SUSPEND;
                default:    state_nxt = ST_DESEL;
            endcase
        end
    end

    // State and source registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_DESEL;
            cpu_src <= 1'b0;
        end else begin
            state <= state_nxt;
            if (any_strobe) begin
                cpu_src <= ce_ok & strobe_cpu;
            end
        end
    end

    // Datapath controls.
    always_comb begin
        load_en = any_strobe & ce_ok;
        step_en = 1'b0;
        unique case (state)
            ST_DESEL:   step_en = 1'b0;
            ST_LOAD,
            ST_ADVANCE,
            ST_SUSPEND: step_en = ~any_strobe & advance;
            default:    step_en = 1'b0;
        endcase
    end

    assert_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (any_strobe && !ce_ok) |=> (state == ST_DESEL && !cpu_src));

    assert_cpu_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_cpu && strobe_ctl && ce_ok) |=> (state == ST_LOAD && cpu_src));

    assert_desel_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DESEL && !any_strobe) |=> (state == ST_DESEL));

endmodule

// File: rtl/burst_counter.sv
module burst_counter
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [BEAT_W-1:0] start_in,
    output logic [BEAT_W-1:0] start_q,
    output logic [BEAT_W-1:0] cnt_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            start_q <= start_in;
            cnt_q   <= '0;
        end else if (step) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assert_count_wraps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cnt_q == BEAT_W'($past(cnt_q) + 1'b1)));

    assert_load_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == '0));

endmodule

// File: rtl/addr_out_reg.sv
module addr_out_reg
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              order_lin,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BEAT_W-1:0] start_q,
    input  logic [BEAT_W-1:0] cnt_q,
    output logic [ADDR_W-1:0] addr_q
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic [BEAT_W-1:0] low_nxt;

    always_comb begin
        low_nxt = beat_low(start_q, cnt_q + 1'b1, order_lin);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= addr_in;
        end else if (step) begin
            addr_q[BEAT_W-1:0] <= low_nxt;
        end
    end

    assert_upper_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (addr_q[ADDR_W-1:BEAT_W] == $past(addr_q[ADDR_W-1:BEAT_W])));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(addr_q));

    assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_q == $past(addr_in)));

    initial begin
        assert_width_ok: assert (HI_W >= 1);
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              advance,
    input  logic              ce_hi0,
    input  logic              ce_hi1,
    input  logic              ce_lo_n,
    input  logic              order_lin,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              sel,
    output logic              cpu_cycle
);

    seq_state_t        state;
    logic              ce_ok;
    logic              load_en;
    logic              step_en;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] cnt_q;

    assign ce_ok = ce_hi0 & ce_hi1 & ~ce_lo_n;

    burst_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_cpu (strobe_cpu),
        .strobe_ctl (strobe_ctl),
        .advance    (advance),
        .ce_ok      (ce_ok),
        .state      (state),
        .cpu_src    (cpu_cycle),
        .load_en    (load_en),
        .step_en    (step_en)
    );

    burst_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_en),
        .step     (step_en),
        .start_in (addr_in[BEAT_W-1:0]),
        .start_q  (start_q),
        .cnt_q    (cnt_q)
    );

    addr_out_reg #(.ADDR_W(ADDR_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_en),
        .step      (step_en),
        .order_lin (order_lin),
        .addr_in   (addr_in),
        .start_q   (start_q),
        .cnt_q     (cnt_q),
        .addr_q    (arr_addr)
    );

    assign sel = (state != ST_DESEL);

    assert_desel_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((strobe_cpu || strobe_ctl) && !ce_ok) |=> ($stable(arr_addr) && !sel));

    assert_advance_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !strobe_cpu && !strobe_ctl) |=> $stable(arr_addr));

endmodule

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;

    localparam int AW = 19;

    typedef struct packed {
        logic          sel;
        logic [AW-1:0] addr;
        logic          cpu;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          strobe_cpu = 1'b0, strobe_ctl = 1'b0, advance = 1'b0;
    logic          ce_hi0 = 1'b1, ce_hi1 = 1'b1, ce_lo_n = 1'b0, order_lin = 1'b0;
    logic [AW-1:0] arr_addr;
    logic          sel, cpu_cycle;

    int tests = 0;
    int fails = 0;

    exp_t  exp_q[$];
    string tag_q[$];

    // Reference state.
    logic          m_sel = 1'b0, m_cpu = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic [1:0]    m_start = '0, m_cnt = '0;

    burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl), .advance(advance),
        .ce_hi0(ce_hi0), .ce_hi1(ce_hi1), .ce_lo_n(ce_lo_n),
        .order_lin(order_lin), .arr_addr(arr_addr), .sel(sel), .cpu_cycle(cpu_cycle)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input exp_t e);
        tests++;
        if (sel !== e.sel || arr_addr !== e.addr || cpu_cycle !== e.cpu) begin
            fails++;
            $display("FAIL %s: actual sel=%0b addr=%h cpu=%0b expected sel=%0b addr=%h cpu=%0b",
                     tag, sel, arr_addr, cpu_cycle, e.sel, e.addr, e.cpu);
        end
    endtask

    // Driver: applies one edge of stimulus and pushes the expected result.
    task automatic cyc(input logic cpu, input logic ctl, input logic adv,
                       input logic [2:0] ce, input logic lin,
                       input logic [AW-1:0] a, input string tag);
        exp_t e;
        logic ok;
        @(negedge clk);
        strobe_cpu = cpu; strobe_ctl = ctl; advance = adv;
        ce_hi0 = ce[2]; ce_hi1 = ce[1]; ce_lo_n = ce[0];
        order_lin = lin; addr_in = a;
        ok = ce[2] && ce[1] && !ce[0];
        if (cpu || ctl) begin
            if (ok) begin
                m_sel = 1'b1; m_addr = a; m_start = a[1:0]; m_cnt = 2'd0; m_cpu = cpu;
            end else begin
                m_sel = 1'b0; m_cpu = 1'b0;
            end
        end else if (adv && m_sel) begin
            m_cnt = m_cnt + 2'd1;
            m_addr[1:0] = lin ? (m_start + m_cnt) : (m_start ^ m_cnt);
        end
        e.sel = m_sel; e.addr = m_addr; e.cpu = m_cpu;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares one item after each rising edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), exp_q.pop_front());
        end
    end

    localparam logic [2:0] CE_ON = 3'b110;

    initial begin : watchdog
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        exp_t r;
        repeat (4) @(negedge clk);
        r.sel = 1'b0; r.addr = '0; r.cpu = 1'b0;
        check("R1 reset", r);
        rst_n = 1'b1;

        // Controller-side load, interleaved burst from low bits 01, wraps.
        cyc(0, 1, 0, CE_ON, 0, 19'h12345, "R2 R3 ctl load");
        cyc(0, 0, 1, CE_ON, 0, 19'h0, "R7 R5 beat1");
        cyc(0, 0, 1, CE_ON, 0, 19'h0, "R7 beat2");
        cyc(0, 0, 1, CE_ON, 0, 19'h0, "R7 beat3");
        cyc(0, 0, 1, CE_ON, 0, 19'h0, "R10 wrap");
        // Linear burst from 10, with suspend in the middle.
        cyc(1, 0, 0, CE_ON, 1, 19'h2ABCE, "R2 R3 cpu load");
        cyc(0, 0, 1, CE_ON, 1, 19'h0, "R6 beat1");
        cyc(0, 0, 0, CE_ON, 1, 19'h7FFFF, "R8 suspend");
        cyc(0, 0, 0, CE_ON, 1, 19'h0, "R8 suspend2");
        cyc(0, 0, 1, CE_ON, 1, 19'h0, "R6 R8 resume");
        cyc(0, 0, 1, CE_ON, 1, 19'h0, "R6 beat3");
        cyc(0, 0, 1, CE_ON, 1, 19'h0, "R10 linear wrap");
        // Deselects by each enable.
        cyc(0, 1, 0, 3'b010, 0, 19'h11111, "R4 ce_hi0 low");
        cyc(0, 0, 1, CE_ON, 0, 19'h0, "R9 advance deselected");
        cyc(1, 0, 0, CE_ON, 0, 19'h00003, "R2 reload");
        cyc(1, 0, 0, 3'b100, 0, 19'h22222, "R4 ce_hi1 low");
        cyc(0, 1, 0, CE_ON, 0, 19'h00007, "R3 ctl reload");
        cyc(0, 1, 1, 3'b111, 0, 19'h33333, "R4 ce_lo_n high");
        cyc(0, 0, 1, CE_ON, 1, 19'h0, "R9 advance deselected2");
        // Priority and back-to-back loads.
        cyc(1, 1, 0, CE_ON, 0, 19'h40001, "R3 both strobes");
        cyc(0, 1, 1, CE_ON, 0, 19'h50002, "R11 load1");
        cyc(1, 0, 1, CE_ON, 0, 19'h60003, "R11 load2");
        cyc(0, 1, 0, CE_ON, 1, 19'h7FFFC, "R11 load3");
        cyc(0, 0, 1, CE_ON, 0, 19'h0, "R7 R5 beat from 00");
        cyc(0, 0, 1, CE_ON, 1, 19'h0, "R6 mode switch");
        cyc(0, 0, 0, 3'b000, 0, 19'h0, "R8 hold no strobe");

        @(negedge clk);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule